// File: doc/BRIEF.md
# Nibble-Register Calendar Clock

This block is a calendar clock whose time lives in sixteen 4-bit registers. Seconds, minutes, hours, day, month and a two-digit year are each kept as a pair of BCD digits, ones digit first. A weekday counter follows them, and the top registers hold control bits. A single-cycle pulse on the 1 Hz input advances the time by one second. Carries ripple through the calendar, and the block knows month lengths and leap years.

The host reaches the clock through three byte-wide locations picked by `sel`. Code 0 is an enable register, code 1 is a command/data port and code 2 is a done-flag register. The host first arms the clock with a command byte. The command selects one of two modes. In stream mode the first data write sets the register index, and later accesses stream bytes through it while the index steps on by itself. In seek mode every data write only moves the index.

Writes are taken on the clock edge while `wrEn` is high. Reads are combinational on `rdData` while `rdEn` is high, and their side effects land on the edge that closes the read.

Top module: `rtc_nibble_clock`

## Requirements
- R1: After reset all sixteen nibbles are 0, the clock is not armed, the enable register reads 0x00 and the done flag is clear.
- R2: While not armed, a read of the data port (sel=1) returns 0x00, and a data write of any byte other than 0x03 or 0x0C leaves the clock unarmed.
- R3: While not armed, writing 0x03 (stream mode) or 0x0C (seek mode) to the data port arms the clock and leaves the index unset. The next data write loads the index from data bits 3:0.
- R4: In stream mode, each data write after the index is set stores data bits 3:0 at the index, sets the done flag and advances the index modulo 16. Each armed data read returns the nibble at the index in bits 3:0, with bits 7:4 zero, and advances the index modulo 16.
- R5: In seek mode, each data write after the index is set reloads the index from data bits 3:0 and sets the done flag, and stores nothing.
- R6: A write to the enable register (sel=0) stores the byte, and the byte reads back. If bit 0 of the byte is set, the clock is disarmed, the index becomes unset and the done flag is set. If bit 0 is clear, the arming and the done flag are left alone.
- R7: A read of the done-flag register (sel=2) returns the flag in bit 7, with the other bits zero, and then inverts the flag.
- R8: Each 1 Hz pulse adds one second. Seconds wrap at 60 into minutes, minutes wrap at 60 into hours, and hours wrap at 24 into the day, all in BCD. Nibble pairs 0/1, 2/3 and 4/5 hold seconds, minutes and hours.
- R9: Nibble pairs 6/7, 8/9 and 10/11 hold day, month and year. A day past the month's length returns to 1 and steps the month. February has 29 days when the year is a multiple of 4. April, June, September and November have 30 days, and the rest have 31. Month 12 wraps to 1 and steps the year, and year 99 wraps to 00.
- R10: Nibble 12 is a weekday count that steps on every day carry and wraps from 6 to 0.
- R11: Time stands still while the clock is unarmed, while nibble 13 bit 0 is set, or while either bit 1 or bit 0 of nibble 15 is set.
- R12: A store to nibble 13 with bit 3 set clears the seconds. If the seconds-tens digit was 3 or more, one minute (with carry) is added first. The value kept in nibble 13 has bit 3 cleared.
- R13: A store to nibble 15 whose bit 0 goes from 0 to 1 clears the seconds.
- R14: A 1 Hz pulse that falls in the same cycle as a stream-mode store is carried over and applied on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle pulse per second |
| wrEn | input | 1 | Write strobe for the selected location |
| rdEn | input | 1 | Read strobe for the selected location |
| sel | input | 2 | Location: 0 enable, 1 data port, 2 done flag |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected location |

## Verification
The assertions assume the host never raises `wrEn` and `rdEn` in the same cycle, and that `sel` is steady for the whole access. The control-side checks depend on this, because they assume at most one location changes per cycle. The stimulus keeps within this assumption because every access is a one-cycle task that raises exactly one strobe, and the strobes are released between accesses. The only overlap the bench creates on purpose is a 1 Hz pulse landing on a store, which the design must defer rather than lose. Each time case is read back in full after a fresh arm and index load.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NIB_W     = 4;
  localparam int NIB_COUNT = 16;
  localparam int IDX_W     = $clog2(NIB_COUNT);

  typedef logic [NIB_COUNT-1:0][NIB_W-1:0] nibFile_t;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_PORT   = 2'd1,
    SEL_DONE   = 2'd2,
    SEL_NONE   = 2'd3
  } portSel_e;

  localparam logic [7:0] CMD_STREAM = 8'h03;
  localparam logic [7:0] CMD_SEEK   = 8'h0C;

  localparam logic [IDX_W-1:0] IDX_WEEK = IDX_W'(12);
  localparam logic [IDX_W-1:0] IDX_HOLD = IDX_W'(13);
  localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(15);

  // Strobes from control to the nibble datapath
  typedef struct packed {
    logic             storeEn;
    logic [IDX_W-1:0] storeIdx;
    logic [NIB_W-1:0] storeData;
    logic             runEn;
  } ctrlStrobe_t;

  function automatic logic [7:0] bcdVal(logic [3:0] tens, logic [3:0] ones);
    return ({4'b0, tens} * 8'd10) + {4'b0, ones};
  endfunction

  function automatic logic [3:0] tensOf(logic [7:0] v);
    logic [7:0] t;
    t = v / 8'd10;
    return t[3:0];
  endfunction

  function automatic logic [3:0] onesOf(logic [7:0] v);
    logic [7:0] o;
    o = v % 8'd10;
    return o[3:0];
  endfunction

  function automatic logic [7:0] monthDays(logic [7:0] mon, logic [7:0] yr);
    case (mon)
      8'd2:                        return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:     return 8'd30;
      default:                     return 8'd31;
    endcase
  endfunction

  // One step of the calendar; fromMinute skips the seconds stage
  function automatic nibFile_t advanceTime(nibFile_t f, logic fromMinute);
    logic [7:0] sec, mins, hrs, day, mon, yr;
    logic [3:0] wk;
    logic       carry;
    nibFile_t   r;
    sec  = bcdVal(f[1], f[0]);
    mins = bcdVal(f[3], f[2]);
    hrs  = bcdVal(f[5], f[4]);
    day  = bcdVal(f[7], f[6]);
    mon  = bcdVal(f[9], f[8]);
    yr   = bcdVal(f[11], f[10]);
    wk   = f[12];
    r     = f;
    carry = 1'b1;
    if (!fromMinute) begin
      if (sec >= 8'd59) sec = 8'd0;
      else begin sec = sec + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      if (mins >= 8'd59) mins = 8'd0;
      else begin mins = mins + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      if (hrs >= 8'd23) hrs = 8'd0;
      else begin hrs = hrs + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      wk = (wk >= 4'd6) ? 4'd0 : wk + 4'd1;
      if (day >= monthDays(mon, yr)) day = 8'd1;
      else begin day = day + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      if (mon >= 8'd12) mon = 8'd1;
      else begin mon = mon + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      yr = (yr >= 8'd99) ? 8'd0 : yr + 8'd1;
    end
    r[0]  = onesOf(sec);  r[1]  = tensOf(sec);
    r[2]  = onesOf(mins); r[3]  = tensOf(mins);
    r[4]  = onesOf(hrs);  r[5]  = tensOf(hrs);
    r[6]  = onesOf(day);  r[7]  = tensOf(day);
    r[8]  = onesOf(mon);  r[9]  = tensOf(mon);
    r[10] = onesOf(yr);   r[11] = tensOf(yr);
    r[12] = wk;
    return r;
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobe_t       strobe,
  output logic              initDone,
  output logic [IDX_W-1:0]  index,
  output logic              doneFlag,
  output logic [DATA_W-1:0] enableReg
);
  logic modeSeek, indexSet;
  logic portWr, portRd, enWr, doneRd;

  assign portWr = wrEn && (sel == SEL_PORT);
  assign portRd = rdEn && (sel == SEL_PORT);
  assign enWr   = wrEn && (sel == SEL_ENABLE);
  assign doneRd = rdEn && (sel == SEL_DONE);

  assign strobe.storeEn   = portWr && initDone && indexSet && !modeSeek;
  assign strobe.storeIdx  = index;
  assign strobe.storeData = wrData[NIB_W-1:0];
  assign strobe.runEn     = initDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initDone  <= 1'b0;
      modeSeek  <= 1'b0;
      indexSet  <= 1'b0;
      index     <= '0;
      doneFlag  <= 1'b0;
      enableReg <= '0;
    end else if (enWr) begin
      enableReg <= wrData;
      if (wrData[0]) begin
        initDone <= 1'b0;
        indexSet <= 1'b0;
        doneFlag <= 1'b1;
      end
    end else if (doneRd) begin
      doneFlag <= ~doneFlag;
    end else if (portWr) begin
      if (!initDone) begin
        if (wrData == DATA_W'(CMD_STREAM) || wrData == DATA_W'(CMD_SEEK)) begin
          initDone <= 1'b1;
          modeSeek <= (wrData == DATA_W'(CMD_SEEK));
          indexSet <= 1'b0;
        end
      end else if (!indexSet || modeSeek) begin
        index    <= wrData[IDX_W-1:0];
        indexSet <= 1'b1;
        if (indexSet) doneFlag <= 1'b1;
      end else begin
        index    <= index + IDX_W'(1);
        doneFlag <= 1'b1;
      end
    end else if (portRd && initDone) begin
      index <= index + IDX_W'(1);
    end
  end

  // Host never strobes read and write together (input assumption)
  p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn));

  p_index_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeEn |=> (index == $past(index) + IDX_W'(1)) && doneFlag);

  p_done_toggle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && sel == SEL_DONE) |=> (doneFlag != $past(doneFlag)));

  p_disarm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_ENABLE && wrData[0]) |=> (!initDone && doneFlag));

  p_arm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_PORT && !initDone && wrData == DATA_W'(CMD_SEEK))
      |=> initDone && !strobe.storeEn);
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  ctrlStrobe_t      strobe,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [NIB_W-1:0] rdNibble
);
  nibFile_t file, storeFile;
  logic     tickPending, tickDue, canRun;

  assign canRun  = strobe.runEn && !file[IDX_HOLD][0] && (file[IDX_STOP][1:0] == 2'b00);
  assign tickDue = tickIn || tickPending;
  assign rdNibble = file[rdIdx];

  // File contents after a host store, including control side effects
  always_comb begin
    storeFile = file;
    if (strobe.storeIdx == IDX_HOLD && strobe.storeData[3]) begin
      if (file[1] >= 4'd3) storeFile = advanceTime(file, 1'b1);
      storeFile[0] = '0;
      storeFile[1] = '0;
      storeFile[IDX_HOLD] = {1'b0, strobe.storeData[2:0]};
    end else if (strobe.storeIdx == IDX_STOP) begin
      if (strobe.storeData[0] && !file[IDX_STOP][0]) begin
        storeFile[0] = '0;
        storeFile[1] = '0;
      end
      storeFile[IDX_STOP] = strobe.storeData;
    end else begin
      storeFile[strobe.storeIdx] = strobe.storeData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      file        <= '0;
      tickPending <= 1'b0;
    end else if (strobe.storeEn) begin
      file        <= storeFile;
      tickPending <= tickDue;
    end else begin
      tickPending <= 1'b0;
      if (tickDue && canRun) file <= advanceTime(file, 1'b0);
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.storeEn && !canRun) |=> $stable(file));

  p_sec_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.storeEn && tickIn && canRun && file[0] < 4'd9)
      |=> file[0] == $past(file[0]) + 4'd1);

  p_round_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeEn && strobe.storeIdx == IDX_HOLD && strobe.storeData[3])
      |=> (file[0] == 4'd0 && file[1] == 4'd0 && !file[IDX_HOLD][3]));

  p_stop_clear_r13: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeEn && strobe.storeIdx == IDX_STOP && strobe.storeData[0] && !file[IDX_STOP][0])
      |=> (file[0] == 4'd0 && file[1] == 4'd0));

  p_tick_defer_r14: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeEn && tickIn) |=> tickDue);
endmodule

// File: rtl/rtc_nibble_clock.sv
module rtc_nibble_clock
  import rtc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick1Hz,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  ctrlStrobe_t       strobe;
  logic              initDone, doneFlag;
  logic [IDX_W-1:0]  index;
  logic [DATA_W-1:0] enableReg;
  logic [NIB_W-1:0]  rdNibble;

  rtc_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .sel(sel),
    .wrData(wrData), .strobe(strobe), .initDone(initDone),
    .index(index), .doneFlag(doneFlag), .enableReg(enableReg)
  );

  rtc_datapath dp_i (
    .clk(clk), .rstN(rstN), .tickIn(tick1Hz), .strobe(strobe),
    .rdIdx(index), .rdNibble(rdNibble)
  );

  always_comb begin
    case (sel)
      SEL_ENABLE: rdData = enableReg;
      SEL_PORT:   rdData = initDone ? DATA_W'(rdNibble) : '0;
      SEL_DONE:   rdData = {doneFlag, {(DATA_W-1){1'b0}}};
      default:    rdData = '0;
    endcase
  end
endmodule

// File: tb/rtc_nibble_clock_tb.sv
module rtc_nibble_clock_tb_top;
  logic       clk = 1'b0, rstN = 1'b0, tick1Hz = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  always #4 clk = ~clk;

  rtc_nibble_clock dut_i (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .wrEn(wrEn), .rdEn(rdEn),
    .sel(sel), .wrData(wrData), .rdData(rdData)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t expQ[$];
  int checks = 0, errors = 0;

  // Monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    item_t it;
    if (rdEn) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read actual=%02h expected=none", rdData);
      end else begin
        it = expQ.pop_front();
        if (rdData !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  task automatic doWrite(input logic [1:0] s, input logic [7:0] d, input logic withTick = 1'b0);
    @(posedge clk); #1;
    sel = s; wrData = d; wrEn = 1'b1; tick1Hz = withTick;
    @(posedge clk); #1;
    wrEn = 1'b0; tick1Hz = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] s, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    expQ.push_back('{e, tag});
    sel = s; rdEn = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic doTick();
    @(posedge clk); #1; tick1Hz = 1'b1;
    @(posedge clk); #1; tick1Hz = 1'b0;
  endtask

  function automatic logic [7:0] o(int v); return 8'(v % 10); endfunction
  function automatic logic [7:0] t(int v); return 8'(v / 10); endfunction

  // R3: arm in stream mode and load the index
  task automatic rearm(input int idx);
    doWrite(2'd0, 8'h01);
    doWrite(2'd1, 8'h03);
    doWrite(2'd1, 8'(idx));
  endtask

  task automatic setTime(input int s, m, h, d, mo, y);
    rearm(0);
    doWrite(2'd1, o(s));  doWrite(2'd1, t(s));
    doWrite(2'd1, o(m));  doWrite(2'd1, t(m));
    doWrite(2'd1, o(h));  doWrite(2'd1, t(h));
    doWrite(2'd1, o(d));  doWrite(2'd1, t(d));
    doWrite(2'd1, o(mo)); doWrite(2'd1, t(mo));
    doWrite(2'd1, o(y));  doWrite(2'd1, t(y));
  endtask

  task automatic checkTime(input int s, m, h, d, mo, y, wk, input string tag);
    rearm(0);
    doRead(2'd1, o(s), tag);  doRead(2'd1, t(s), tag);
    doRead(2'd1, o(m), tag);  doRead(2'd1, t(m), tag);
    doRead(2'd1, o(h), tag);  doRead(2'd1, t(h), tag);
    doRead(2'd1, o(d), tag);  doRead(2'd1, t(d), tag);
    doRead(2'd1, o(mo), tag); doRead(2'd1, t(mo), tag);
    doRead(2'd1, o(y), tag);  doRead(2'd1, t(y), tag);
    doRead(2'd1, 8'(wk), tag);
  endtask

  task automatic writeNib(input int idx, input logic [7:0] v);
    rearm(idx);
    doWrite(2'd1, v);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    doRead(2'd2, 8'h00, "R1 done flag after reset");
    doRead(2'd0, 8'h00, "R1 enable register after reset");
    doRead(2'd1, 8'h00, "R1 R2 port read while unarmed");
    checkTime(0, 0, 0, 0, 0, 0, 0, "R1 nibbles zero after reset");
    // R7 toggle sequence: rearm left done set
    doRead(2'd2, 8'h80, "R7 done bit returned");
    doRead(2'd2, 8'h00, "R7 done bit toggled");

    // R2 unarmed ignores other bytes
    doWrite(2'd0, 8'h01);
    doWrite(2'd1, 8'h05);
    doRead(2'd1, 8'h00, "R2 non-command byte leaves clock unarmed");

    // R6 enable byte with bit 0 clear
    doRead(2'd2, 8'h80, "R6 disarm sets done");
    doWrite(2'd0, 8'h02);
    doRead(2'd0, 8'h02, "R6 enable byte stored");
    doRead(2'd2, 8'h00, "R6 bit0 clear leaves done alone");

    // R4 store sets done; R8/R9/R10 non-leap February
    setTime(59, 59, 23, 28, 2, 99);
    doWrite(2'd1, 8'h06);
    doRead(2'd2, 8'h80, "R4 store sets done");
    doTick();
    checkTime(0, 0, 0, 1, 3, 99, 0, "R9 R10 February non-leap");

    setTime(59, 59, 23, 28, 2, 4);
    doTick();
    checkTime(0, 0, 0, 29, 2, 4, 1, "R9 leap February");

    setTime(59, 59, 23, 31, 12, 99);
    doTick();
    checkTime(0, 0, 0, 1, 1, 0, 2, "R9 R10 year wrap");

    setTime(59, 59, 23, 30, 4, 10);
    doTick();
    checkTime(0, 0, 0, 1, 5, 10, 3, "R9 thirty-day month");

    // R8 second and hour carries
    setTime(8, 9, 9, 15, 6, 20);
    doTick(); doTick();
    checkTime(10, 9, 9, 15, 6, 20, 3, "R8 seconds ones carry");
    setTime(59, 59, 9, 15, 6, 20);
    doTick();
    checkTime(0, 0, 10, 15, 6, 20, 3, "R8 hour carry");

    // R11 hold conditions
    writeNib(13, 8'h01);
    doTick();
    checkTime(0, 0, 10, 15, 6, 20, 3, "R11 hold bit in nibble 13");
    writeNib(13, 8'h00);
    writeNib(15, 8'h02);
    doTick();
    checkTime(0, 0, 10, 15, 6, 20, 3, "R11 stop bit 1 in nibble 15");
    writeNib(15, 8'h00);
    doWrite(2'd0, 8'h01);
    doTick();
    checkTime(0, 0, 10, 15, 6, 20, 3, "R11 unarmed clock holds");
    doTick();
    checkTime(1, 0, 10, 15, 6, 20, 3, "R11 resumes when released");

    // R12 rounding control
    setTime(45, 10, 10, 15, 6, 20);
    writeNib(13, 8'h0A);
    checkTime(0, 11, 10, 15, 6, 20, 3, "R12 round up at tens 3 or more");
    rearm(13);
    doRead(2'd1, 8'h02, "R12 bit3 dropped from nibble 13");
    setTime(25, 10, 10, 15, 6, 20);
    writeNib(13, 8'h08);
    checkTime(0, 10, 10, 15, 6, 20, 3, "R12 clear without round up");

    // R13 rising edge of nibble 15 bit 0
    setTime(37, 20, 10, 15, 6, 20);
    writeNib(15, 8'h01);
    checkTime(0, 20, 10, 15, 6, 20, 3, "R13 rising bit0 clears seconds");
    setTime(12, 20, 10, 15, 6, 20);
    writeNib(15, 8'h01);
    checkTime(12, 20, 10, 15, 6, 20, 3, "R13 no edge keeps seconds");
    writeNib(15, 8'h00);
    // R4 index wrapped from 15 to 0
    doRead(2'd1, 8'h02, "R4 index wraps modulo 16");

    // R5 seek mode
    doWrite(2'd0, 8'h01);
    doWrite(2'd1, 8'h0C);
    doWrite(2'd1, 8'h03);
    doRead(2'd2, 8'h80, "R3 arm leaves done from disarm");
    doWrite(2'd1, 8'h05);
    doRead(2'd2, 8'h80, "R5 seek write sets done");
    doRead(2'd1, 8'h01, "R5 seek reload points at nibble 5");
    doRead(2'd1, 8'h05, "R5 read advances to nibble 6");
    rearm(3);
    doRead(2'd1, 8'h02, "R5 seek write stored nothing");

    // R14 tick coinciding with a store
    setTime(10, 20, 10, 15, 6, 20);
    doWrite(2'd1, 8'h04, 1'b1);
    checkTime(11, 20, 10, 15, 6, 20, 4, "R14 tick deferred past store");

    repeat (2) @(posedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard drain actual=%0d expected=0", expQ.size());
    end
    summary();
    $finish;
  end
endmodule